// File: doc/BRIEF.md
# Command Ring Fetch Engine

This block pulls 32-bit command words out of a circular buffer in system memory and presents them one by one to a downstream packet parser. Host software programs the buffer's base address and fills the buffer. It then announces new work by writing the write pointer through a doorbell strobe. The engine compares its own read pointer with that write pointer. It issues single-word memory reads, places the returned words in a small prefetch FIFO, and streams them out through a valid/ready handshake.

Both pointers count words, and the ring holds a power-of-two number of words, so every pointer wraps through a mask. The host can observe progress in three ways. It can read the read pointer directly, or read a status word and a free-space figure. It can also poll memory: each time the read pointer moves, the engine writes its new value to an address the host supplies, unless a control bit turns this off. A 4-bit mode field in the control word switches fetching on or off.

Top module: `cmd_ring_fetch`

## Requirements
- R1: Pointers count 32-bit words. Each memory read request carries the byte address `host_ring_base + 4 * host_rptr`.
- R2: The read pointer steps by one word and wraps from the last ring entry to entry 0. A doorbell value is reduced to its low `RING_AW` bits (ring size minus one as mask), and all higher bits are ignored.
- R3: After each doorbell write, the engine fetches every word from the read pointer up to, but not including, the new write pointer. It delivers them on `cmd_data` in ring order, then stops requesting once the read pointer equals the write pointer.
- R4: Control bits 31:28 form the mode. With mode 0, no new memory request is issued. With any nonzero mode, fetching runs.
- R5: At most one memory request is outstanding. A request is only issued while the prefetch FIFO (`FIFO_DEPTH` words) has room, so a stalled consumer loses no word and the FIFO never holds more than `FIFO_DEPTH` entries.
- R6: `host_status` bits 11:0 give the FIFO entry count, bit 16 is busy, bit 31 is active (mode nonzero), and all other bits are 0. Busy is low only when the read pointer equals the write pointer, the FIFO is empty and no request is pending.
- R7: `host_free_bytes` equals `((rptr - wptr) mod SIZE) * 4`, where SIZE is the ring size in words. A zero result is replaced by `SIZE * 4`.
- R8: With control bit 27 clear, a change of the read pointer raises `wb_valid` in the next cycle. `wb_data` then carries the new read pointer (zero extended) and `wb_addr` carries `host_wb_addr`, and both hold stable until `wb_ready`. A later pointer value is sent after the stalled one completes.
- R9: With control bit 27 set, the read pointer is not written back.
- R10: `cmd_data` holds stable while `cmd_valid` is high and `cmd_ready` is low.
- R11: After reset, read pointer, write pointer and mode are 0. The status word is 0, free space is `SIZE * 4`, and no valid output is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_ring_base | input | ADDR_W | Byte address of ring entry 0 |
| host_wb_addr | input | ADDR_W | Byte address for read-pointer writeback |
| host_ctrl_wr | input | 1 | Control word write strobe |
| host_ctrl_wdata | input | 32 | Control word: bits 31:28 mode, bit 27 writeback off |
| host_db_wr | input | 1 | Doorbell (write pointer) write strobe |
| host_db_wdata | input | 32 | New write pointer in words |
| host_rptr | output | RING_AW | Current read pointer in words |
| host_status | output | 32 | FIFO count, busy and active flags |
| host_free_bytes | output | RING_AW+3 | Free space in bytes as seen by the host |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory read request accepted |
| mem_req_addr | output | ADDR_W | Byte address of requested word |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Returned command word |
| cmd_valid | output | 1 | Command word valid toward parser |
| cmd_ready | input | 1 | Parser accepts word |
| cmd_data | output | 32 | Command word |
| wb_valid | output | 1 | Read-pointer writeback valid |
| wb_ready | input | 1 | Writeback accepted |
| wb_addr | output | ADDR_W | Writeback byte address |
| wb_data | output | 32 | Read pointer value written back |

## Verification
A read pointer that is off by one, or that wraps wrongly, shows up within a single fetch. The memory request addresses no longer match `host_ring_base + 4*rptr`, so the delivered word sequence leaves ring order, and the free-space figure drifts. A lost FIFO count or a missed full condition shows up as soon as the parser stalls: more than `FIFO_DEPTH` requests appear, or words go missing once the stall ends. A stuck writeback or busy flag appears a cycle after the pointer settles, as a missing or stale `wb_data` or as busy staying high with nothing left to fetch.

// File: rtl/cmd_ring_pkg.sv
package cmd_ring_pkg;

    // Control word layout (host visible)
    localparam int CTRL_MODE_LSB = 28;
    localparam int CTRL_MODE_W   = 4;
    localparam int CTRL_NOWB_BIT = 27;

    // Status word layout (host visible)
    localparam int STAT_CNT_W    = 12;
    localparam int STAT_BUSY_BIT = 16;
    localparam int STAT_ACT_BIT  = 31;

    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,
        FS_REQ  = 2'd1,
        FS_WAIT = 2'd2
    } fetch_st_e;

endpackage

// File: rtl/cmd_ring_ctrl_regs.sv
module cmd_ring_ctrl_regs
    import cmd_ring_pkg::*;
#(
    parameter int RING_AW = 10
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ctrl_wr,
    input  logic [CTRL_MODE_W-1:0] ctrl_mode,
    input  logic                   ctrl_nowb,
    input  logic                   db_wr,
    input  logic [RING_AW-1:0]     db_wptr,
    output logic                   fetch_en,
    output logic                   nowb,
    output logic [RING_AW-1:0]     wptr
);

    typedef struct packed {
        logic [CTRL_MODE_W-1:0] mode;
        logic                   nowb;
        logic [RING_AW-1:0]     wptr;
    } regs_t;

    regs_t q, d;

    always_comb begin
        d = q;
        if (ctrl_wr) begin
            d.mode = ctrl_mode;
            d.nowb = ctrl_nowb;
        end
        if (db_wr) begin
            d.wptr = db_wptr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign fetch_en = (q.mode != '0);
    assign nowb     = q.nowb;
    assign wptr     = q.wptr;

endmodule

// File: rtl/cmd_ring_fetch_ctl.sv
module cmd_ring_fetch_ctl
    import cmd_ring_pkg::*;
#(
    parameter int RING_AW = 10,
    parameter int ADDR_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fetch_en,
    input  logic [RING_AW-1:0] wptr,
    input  logic [ADDR_W-1:0]  ring_base,
    input  logic               fifo_full,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic [ADDR_W-1:0]  mem_req_addr,
    input  logic               mem_rsp_valid,
    output logic               push,
    output logic               pending,
    output logic [RING_AW-1:0] rptr
);

    localparam int PAD_W = ADDR_W - RING_AW - 2;

    typedef struct packed {
        fetch_st_e          st;
        logic [RING_AW-1:0] rptr;
    } ctl_t;

    ctl_t q, d;

    always_comb begin
        d    = q;
        push = 1'b0;
        unique case (q.st)
            FS_IDLE: begin
                if (fetch_en && (q.rptr != wptr) && !fifo_full) begin
                    d.st = FS_REQ;
                end
            end
            FS_REQ: begin
                if (mem_req_ready) begin
                    d.st = FS_WAIT;
                end
            end
            FS_WAIT: begin
                if (mem_rsp_valid) begin
                    push   = 1'b1;
                    d.rptr = q.rptr + 1'b1;
                    d.st   = FS_IDLE;
                end
            end
            default: d.st = FS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: FS_IDLE, rptr: '0};
        end else begin
            q <= d;
        end
    end

    assign mem_req_valid = (q.st == FS_REQ);
    assign mem_req_addr  = ring_base + {{PAD_W{1'b0}}, q.rptr, 2'b00};
    assign pending       = (q.st != FS_IDLE);
    assign rptr          = q.rptr;

endmodule

// File: rtl/cmd_ring_fifo.sv
module cmd_ring_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [W-1:0]               push_data,
    output logic                       out_valid,
    input  logic                       out_ready,
    output logic [W-1:0]               out_data,
    output logic [$clog2(DEPTH):0]     count,
    output logic                       full
);

    localparam int PW = $clog2(DEPTH);
    localparam int CW = PW + 1;

    typedef struct packed {
        logic [PW-1:0] wr;
        logic [PW-1:0] rd;
        logic [CW-1:0] cnt;
    } fifo_t;

    fifo_t q, d;
    logic [W-1:0] store [DEPTH];
    logic pop;

    always_comb begin
        d   = q;
        pop = (q.cnt != '0) && out_ready;
        if (push) begin
            d.wr = q.wr + 1'b1;
        end
        if (pop) begin
            d.rd = q.rd + 1'b1;
        end
        case ({push, pop})
            2'b10:   d.cnt = q.cnt + 1'b1;
            2'b01:   d.cnt = q.cnt - 1'b1;
            default: d.cnt = q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_ff @(posedge clk) begin
        if (push) begin
            store[q.wr] <= push_data;
        end
    end

    assign out_valid = (q.cnt != '0);
    assign out_data  = store[q.rd];
    assign count     = q.cnt;
    assign full      = (q.cnt == CW'(DEPTH));

endmodule

// File: rtl/cmd_ring_wb.sv
module cmd_ring_wb #(
    parameter int RING_AW = 10,
    parameter int ADDR_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [RING_AW-1:0] rptr,
    input  logic               nowb,
    input  logic [ADDR_W-1:0]  dest_addr,
    output logic               wb_valid,
    input  logic               wb_ready,
    output logic [ADDR_W-1:0]  wb_addr,
    output logic [31:0]        wb_data
);

    typedef struct packed {
        logic               valid;
        logic [RING_AW-1:0] sent;
        logic [ADDR_W-1:0]  addr;
    } wb_t;

    wb_t  q, d;
    logic stalled;

    always_comb begin
        d       = q;
        stalled = q.valid && !wb_ready;
        if (q.valid && wb_ready) begin
            d.valid = 1'b0;
        end
        if (!stalled && !nowb && (rptr != q.sent)) begin
            d.valid = 1'b1;
            d.sent  = rptr;
            d.addr  = dest_addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign wb_valid = q.valid;
    assign wb_addr  = q.addr;
    assign wb_data  = {{(32 - RING_AW){1'b0}}, q.sent};

endmodule

// File: rtl/cmd_ring_fetch.sv
module cmd_ring_fetch
    import cmd_ring_pkg::*;
#(
    parameter int RING_AW    = 10,
    parameter int FIFO_DEPTH = 8,
    parameter int ADDR_W     = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    host_ring_base,
    input  logic [ADDR_W-1:0]    host_wb_addr,
    input  logic                 host_ctrl_wr,
    input  logic [31:0]          host_ctrl_wdata,
    input  logic                 host_db_wr,
    input  logic [31:0]          host_db_wdata,
    output logic [RING_AW-1:0]   host_rptr,
    output logic [31:0]          host_status,
    output logic [RING_AW+2:0]   host_free_bytes,
    output logic                 mem_req_valid,
    input  logic                 mem_req_ready,
    output logic [ADDR_W-1:0]    mem_req_addr,
    input  logic                 mem_rsp_valid,
    input  logic [31:0]          mem_rsp_data,
    output logic                 cmd_valid,
    input  logic                 cmd_ready,
    output logic [31:0]          cmd_data,
    output logic                 wb_valid,
    input  logic                 wb_ready,
    output logic [ADDR_W-1:0]    wb_addr,
    output logic [31:0]          wb_data
);

    localparam int CNT_W  = $clog2(FIFO_DEPTH) + 1;
    localparam int FREE_W = RING_AW + 3;
    localparam logic [FREE_W-1:0] RING_BYTES = FREE_W'(1) << (RING_AW + 2);

    logic               ctl_fetch_en;
    logic               ctl_nowb;
    logic [RING_AW-1:0] ctl_wptr;
    logic [RING_AW-1:0] rd_ptr;
    logic               fifo_push;
    logic               fifo_full;
    logic [CNT_W-1:0]   fifo_cnt;
    logic               req_pending;
    logic               ring_busy;
    logic [RING_AW-1:0] ptr_gap;
    logic               unused_hi;

    assign unused_hi = ^{host_ctrl_wdata[CTRL_NOWB_BIT-1:0], host_db_wdata[31:RING_AW]};

    cmd_ring_ctrl_regs #(.RING_AW(RING_AW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_wr   (host_ctrl_wr),
        .ctrl_mode (host_ctrl_wdata[CTRL_MODE_LSB +: CTRL_MODE_W]),
        .ctrl_nowb (host_ctrl_wdata[CTRL_NOWB_BIT]),
        .db_wr     (host_db_wr),
        .db_wptr   (host_db_wdata[RING_AW-1:0]),
        .fetch_en  (ctl_fetch_en),
        .nowb      (ctl_nowb),
        .wptr      (ctl_wptr)
    );

    cmd_ring_fetch_ctl #(.RING_AW(RING_AW), .ADDR_W(ADDR_W)) u_fetch (
        .clk           (clk),
        .rst_n         (rst_n),
        .fetch_en      (ctl_fetch_en),
        .wptr          (ctl_wptr),
        .ring_base     (host_ring_base),
        .fifo_full     (fifo_full),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .push          (fifo_push),
        .pending       (req_pending),
        .rptr          (rd_ptr)
    );

    cmd_ring_fifo #(.W(32), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (fifo_push),
        .push_data (mem_rsp_data),
        .out_valid (cmd_valid),
        .out_ready (cmd_ready),
        .out_data  (cmd_data),
        .count     (fifo_cnt),
        .full      (fifo_full)
    );

    cmd_ring_wb #(.RING_AW(RING_AW), .ADDR_W(ADDR_W)) u_wb (
        .clk       (clk),
        .rst_n     (rst_n),
        .rptr      (rd_ptr),
        .nowb      (ctl_nowb),
        .dest_addr (host_wb_addr),
        .wb_valid  (wb_valid),
        .wb_ready  (wb_ready),
        .wb_addr   (wb_addr),
        .wb_data   (wb_data)
    );

    always_comb begin
        ring_busy   = (rd_ptr != ctl_wptr) || (fifo_cnt != '0) || req_pending;
        host_status = '0;
        host_status[STAT_CNT_W-1:0]  = STAT_CNT_W'(fifo_cnt);
        host_status[STAT_BUSY_BIT]   = ring_busy;
        host_status[STAT_ACT_BIT]    = ctl_fetch_en;
        ptr_gap         = rd_ptr - ctl_wptr;
        host_free_bytes = (ptr_gap == '0) ? RING_BYTES
                                          : {1'b0, ptr_gap, 2'b00};
    end

    assign host_rptr = rd_ptr;

endmodule

// File: rtl/cmd_ring_fetch_chk.sv
module cmd_ring_fetch_chk #(
    parameter int RING_AW    = 10,
    parameter int FIFO_DEPTH = 8,
    parameter int ADDR_W     = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic [RING_AW-1:0] host_rptr,
    input logic [31:0]        host_status,
    input logic [RING_AW+2:0] host_free_bytes,
    input logic               mem_req_valid,
    input logic               mem_req_ready,
    input logic [ADDR_W-1:0]  mem_req_addr,
    input logic               cmd_valid,
    input logic               cmd_ready,
    input logic [31:0]        cmd_data,
    input logic               wb_valid,
    input logic               wb_ready,
    input logic [31:0]        wb_data,
    input logic               ctl_nowb
);

    assert_ptr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(host_rptr) |-> host_rptr == RING_AW'($past(host_rptr) + 1'b1));

    assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    assert_fifo_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        host_status[11:0] <= 12'(FIFO_DEPTH));

    assert_off_no_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_status[31] && !mem_req_valid) |=> !mem_req_valid);

    assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !host_status[16] |-> (!cmd_valid && !mem_req_valid && host_status[11:0] == 12'd0));

    assert_free_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (host_free_bytes != '0) && (host_free_bytes[1:0] == 2'b00));

    assert_wb_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_data)));

    assert_nowb_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_nowb && !wb_valid) |=> !wb_valid);

    assert_cmd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_data)));

endmodule

bind cmd_ring_fetch cmd_ring_fetch_chk #(
    .RING_AW(RING_AW), .FIFO_DEPTH(FIFO_DEPTH), .ADDR_W(ADDR_W)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .host_rptr       (host_rptr),
    .host_status     (host_status),
    .host_free_bytes (host_free_bytes),
    .mem_req_valid   (mem_req_valid),
    .mem_req_ready   (mem_req_ready),
    .mem_req_addr    (mem_req_addr),
    .cmd_valid       (cmd_valid),
    .cmd_ready       (cmd_ready),
    .cmd_data        (cmd_data),
    .wb_valid        (wb_valid),
    .wb_ready        (wb_ready),
    .wb_data         (wb_data),
    .ctl_nowb        (ctl_nowb)
);

// File: tb/cmd_ring_fetch_tb.sv
module cmd_ring_fetch_tb;

    localparam int CLK_PERIOD = 10;
    localparam int AW    = 4;
    localparam int SIZE  = 1 << AW;
    localparam int DEPTH = 4;
    localparam logic [31:0] BASE   = 32'h0001_0000;
    localparam logic [31:0] WBADDR = 32'h0002_0040;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_ctrl_wr = 1'b0, host_db_wr = 1'b0;
    logic [31:0] host_ctrl_wdata = '0, host_db_wdata = '0;
    logic [AW-1:0] host_rptr;
    logic [31:0] host_status;
    logic [AW+2:0] host_free_bytes;
    logic mem_req_valid, mem_req_ready = 1'b1;
    logic [31:0] mem_req_addr;
    logic mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic cmd_valid, cmd_ready = 1'b1;
    logic [31:0] cmd_data;
    logic wb_valid, wb_ready = 1'b1;
    logic [31:0] wb_addr, wb_data;

    int checks = 0, errors = 0;
    int nreq = 0, rx_n = 0, wb_n = 0;
    logic [31:0] req_log [64];
    logic [31:0] rx [64];
    logic [31:0] wb_last_data, wb_last_addr;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmd_ring_fetch #(.RING_AW(AW), .FIFO_DEPTH(DEPTH), .ADDR_W(32)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .host_ring_base(BASE), .host_wb_addr(WBADDR),
        .host_ctrl_wr(host_ctrl_wr), .host_ctrl_wdata(host_ctrl_wdata),
        .host_db_wr(host_db_wr), .host_db_wdata(host_db_wdata),
        .host_rptr(host_rptr), .host_status(host_status), .host_free_bytes(host_free_bytes),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
        .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_addr(wb_addr), .wb_data(wb_data)
    );

    function automatic logic [31:0] word_at(int idx);
        return 32'hC0DE_0000 + 32'(idx);
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic write_ctrl(logic [31:0] v);
        host_ctrl_wr = 1'b1; host_ctrl_wdata = v; tick(); host_ctrl_wr = 1'b0;
    endtask

    task automatic ring_doorbell(logic [31:0] v);
        host_db_wr = 1'b1; host_db_wdata = v; tick(); host_db_wr = 1'b0;
    endtask

    task automatic wait_idle(int limit);
        for (int i = 0; i < limit; i++) begin
            if (!host_status[16]) break;
            tick();
        end
        repeat (3) tick();
    endtask

    // memory model: one response per accepted request
    initial begin
        forever begin
            @(negedge clk);
            if (mem_req_valid && mem_req_ready) begin
                logic [31:0] a;
                a = mem_req_addr;
                if (nreq < 64) req_log[nreq] = a;
                nreq++;
                @(posedge clk);
                repeat (nreq % 3) @(posedge clk);
                #1;
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = word_at(int'((a - BASE) >> 2));
                @(posedge clk);
                #1;
                mem_rsp_valid = 1'b0;
            end
        end
    end

    // handshake monitors
    initial begin
        forever begin
            @(negedge clk);
            if (cmd_valid && cmd_ready) begin
                if (rx_n < 64) rx[rx_n] = cmd_data;
                rx_n++;
            end
            if (wb_valid && wb_ready) begin
                wb_n++;
                wb_last_data = wb_data;
                wb_last_addr = wb_addr;
            end
        end
    end

    task automatic expect_words(string tag, int first, int count);
        chk({tag, " word count"}, 32'(rx_n), 32'(count));
        for (int i = 0; i < count && i < rx_n; i++) begin
            chk({tag, " word order"}, rx[i], word_at((first + i) % SIZE));
        end
    endtask

    task automatic t_reset();
        chk("R11 rptr", 32'(host_rptr), 0);
        chk("R11 status", host_status, 0);
        chk("R11 R7 free", 32'(host_free_bytes), SIZE * 4);
        chk("R11 valids", {29'd0, cmd_valid, mem_req_valid, wb_valid}, 0);
    endtask

    task automatic t_mode_off();
        ring_doorbell(32'd3);
        repeat (20) tick();
        chk("R4 no request", 32'(nreq), 0);
        chk("R4 rptr held", 32'(host_rptr), 0);
        chk("R6 active low busy high", host_status, 32'h0001_0000);
    endtask

    task automatic t_basic();
        rx_n = 0;
        write_ctrl(32'h2000_0000);
        wait_idle(200);
        expect_words("R3 basic", 0, 3);
        chk("R3 requests", 32'(nreq), 3);
        for (int i = 0; i < 3; i++) chk("R1 address", req_log[i], BASE + 32'(4 * i));
        chk("R6 idle status", host_status, 32'h8000_0000);
        chk("R7 free empty", 32'(host_free_bytes), SIZE * 4);
        chk("R8 wb data", wb_last_data, 32'd3);
        chk("R8 wb addr", wb_last_addr, WBADDR);
    endtask

    task automatic t_backpressure();
        logic [31:0] held;
        int base_req;
        rx_n = 0;
        base_req = nreq;
        cmd_ready = 1'b0;
        ring_doorbell(32'd12);
        repeat (60) tick();
        chk("R5 fifo count", {20'd0, host_status[11:0]}, DEPTH);
        chk("R5 requests bounded", 32'(nreq - base_req), DEPTH);
        chk("R5 no request when full", {31'd0, mem_req_valid}, 0);
        chk("R5 rptr", 32'(host_rptr), 3 + DEPTH);
        chk("R6 busy active", host_status & 32'h8001_0000, 32'h8001_0000);
        chk("R7 free partial", 32'(host_free_bytes), ((3 + DEPTH - 12 + SIZE) % SIZE) * 4);
        held = cmd_data;
        repeat (5) tick();
        chk("R10 data held", cmd_data, held);
        chk("R10 head word", held, word_at(3));
        cmd_ready = 1'b1;
        wait_idle(400);
        expect_words("R5 no loss", 3, 9);
        chk("R5 final rptr", 32'(host_rptr), 12);
    endtask

    task automatic t_wrap();
        rx_n = 0;
        ring_doorbell(32'd2);
        wait_idle(400);
        expect_words("R2 wrap", 12, 6);
        chk("R2 rptr after wrap", 32'(host_rptr), 2);
        chk("R1 wrapped address", req_log[nreq - 2], BASE);
        rx_n = 0;
        ring_doorbell(32'h1234_0015);
        wait_idle(400);
        expect_words("R2 masked doorbell", 2, 3);
        chk("R2 masked rptr", 32'(host_rptr), 5);
    endtask

    task automatic t_writeback_ctl();
        int wb_before;
        rx_n = 0;
        write_ctrl(32'h2800_0000);
        wb_before = wb_n;
        ring_doorbell(32'd8);
        wait_idle(400);
        expect_words("R9 fetch still runs", 5, 3);
        chk("R9 no writeback", 32'(wb_n - wb_before), 0);
        wb_ready = 1'b0;
        write_ctrl(32'h2000_0000);
        ring_doorbell(32'd10);
        wait_idle(400);
        chk("R8 stalled valid", {31'd0, wb_valid}, 1);
        chk("R8 stalled data", wb_data, 32'd8);
        wb_ready = 1'b1;
        repeat (6) tick();
        chk("R8 later value sent", wb_last_data, 32'd10);
        chk("R8 addr", wb_last_addr, WBADDR);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        tick();
        t_reset();
        t_mode_off();
        t_basic();
        t_backpressure();
        t_wrap();
        t_writeback_ctl();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule